// File: doc/BRIEF.md
# Block-Mode FIFO Service Controller

This block sits between software and the word shifter of a serial port and manages the transmit and receive FIFOs in block mode. Software programs a word count for each direction and then starts the controller. From that point the controller raises a service request each time one block of data can be moved. For transmit, that means the FIFO has room for one block. For receive, it means one block of data is waiting. Software moves that block through a small register port and acknowledges it. The controller signals nothing more in that direction until both the acknowledge and the block's data movement have happened.

Completion of a transfer is reported separately for each direction, by two terminal-count flags. These track the words actually exchanged with the shifter, not the FIFO fill levels. A final block that is shorter than a full block is granted with exactly the words still remaining. The controller has two states, paused and running. Software may load transmit words while paused. The shifter may take transmit words only while running.

Flags are cleared by writing a one to them. Flags that are never acknowledged stay set, even across the programming of a new transfer. The single interrupt line is the OR of all flags, each gated by its own enable bit.

Top module: `blksvc_top`

## Requirements
- R1: After reset, every flag, every interrupt enable, `irq`, `line_run`, `tx_ready` and both FIFO levels read as zero.
- R2: Bit 0 of the control register (address 0) selects running (1) or paused (0), and `line_run` follows it. Words written to address 5 are queued while paused. A `tx_pop` while paused leaves the transmit level unchanged. Words reach `tx_word` in the order they were written.
- R3: With a nonzero transmit count programmed (address 1) and an empty transmit FIFO, the output block flag (flag bit 0) is clear while paused and sets within two cycles of entering run, without any pre-fill.
- R4: The output block flag grants min(BLK, words still to write). It sets again only after it has been acknowledged, the granted words have been written, and the FIFO has room for the next grant.
- R5: The input block flag (flag bit 1) sets when the receive FIFO holds min(BLK, words still to read) words, where the receive count is programmed at address 2. Data read from address 6 comes out in arrival order.
- R6: The flags (address 3) are write-one-to-clear. A flag stays set, and `irq` stays high, until it is acknowledged, even across a pause and the programming of a new count. Once every block and both terminal flags are acknowledged, the flags read zero and `irq` is low.
- R7: The output terminal flag (bit 2) sets when the shifter takes the programmed number of transmit words. The input terminal flag (bit 3) sets when the shifter delivers the programmed number of receive words. Neither sets one word early.
- R8: `irq` equals the OR of the flags ANDed with the enable register (address 4, same bit layout), in the same cycle as the flag register.
- R9: When fewer than BLK words remain, the final block flag is raised for exactly the remaining words.
- R10: A push into a full FIFO is dropped, and a pop from an empty FIFO is ignored. The level register (address 7) reports the transmit level in bits 7:0 and the receive level in bits 15:8.
- R11: Pausing keeps the transfer counters. After resuming, the terminal flag fires on the programmed total of words, counted across the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid next cycle |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| line_run | output | 1 | Controller in run state |
| tx_pop | input | 1 | Shifter takes the head transmit word |
| tx_ready | output | 1 | A transmit word is available to the shifter |
| tx_word | output | DATA_W | Head transmit word |
| rx_push | input | 1 | Shifter delivers a receive word |
| rx_word | input | DATA_W | Receive word |
| rx_room | output | 1 | Receive FIFO can accept a word |
| irq | output | 1 | Masked OR of pending flags |

## Verification
A wrong grant counter inside the block shows up quickly at the register port. Either a block flag re-raises before the granted words arrive, or it never re-raises. The sweep reads the flags two cycles after each write, pop or push, so such an error appears within a few cycles. A stuck or miscounted terminal counter shows up as a completion flag one word early or missing on the last word. A dropped acknowledge shows up as `irq` staying high after the last block.

// File: rtl/blksvc_pkg.sv
`timescale 1ns/1ps
package blksvc_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_OLEN  = 3'd1,
    A_ILEN  = 3'd2,
    A_FLAGS = 3'd3,
    A_IRQEN = 3'd4,
    A_TXD   = 3'd5,
    A_RXD   = 3'd6,
    A_LVL   = 3'd7
  } reg_addr_e;

  localparam int NFLAG  = 4;
  localparam int F_OBLK = 0;
  localparam int F_IBLK = 1;
  localparam int F_OMAX = 2;
  localparam int F_IMAX = 3;
endpackage

// File: rtl/blksvc_fifo.sv
`timescale 1ns/1ps
module blksvc_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty,
  output logic [LVL_W-1:0]  level
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [LVL_W-1:0]  cnt;
  logic              do_push, do_pop;

  assign full    = (cnt == LVL_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

  assign rdata = mem[rp];
  assign level = cnt;
endmodule

// File: rtl/blksvc_dir.sv
`timescale 1ns/1ps
// One transfer direction: block grants and terminal count.
module blksvc_dir #(
  parameter int CNT_W = 16,
  parameter int LVL_W = 4,
  parameter int BLK   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  input  logic             gate,
  input  logic             svc_flag,
  input  logic [LVL_W-1:0] avail,
  input  logic             sw_xfer,
  input  logic             line_xfer,
  output logic             svc_set,
  output logic             max_set
);
  logic [CNT_W-1:0] total_q, sw_q, owed_q, line_q;
  logic [CNT_W-1:0] rem, need;

  assign rem  = total_q - sw_q;
  assign need = (rem < CNT_W'(BLK)) ? rem : CNT_W'(BLK);

  // a new block is offered only once the previous one is acked and moved
  assign svc_set = gate && !svc_flag && (owed_q == '0) && (rem != '0) &&
                   (CNT_W'(avail) >= need);
  assign max_set = line_xfer && (total_q != '0) && (line_q != total_q) &&
                   ((line_q + 1'b1) == total_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      sw_q    <= '0;
      owed_q  <= '0;
      line_q  <= '0;
    end else if (restart) begin
      total_q <= len;
      sw_q    <= '0;
      owed_q  <= '0;
      line_q  <= '0;
    end else begin
      if (sw_xfer && sw_q != total_q) sw_q <= sw_q + 1'b1;
      if (svc_set)
        owed_q <= need - CNT_W'(sw_xfer);
      else if (sw_xfer && owed_q != '0)
        owed_q <= owed_q - 1'b1;
      if (line_xfer && line_q != total_q) line_q <= line_q + 1'b1;
    end
  end
endmodule

// File: rtl/blksvc_top.sv
`timescale 1ns/1ps
module blksvc_top
  import blksvc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int BLK    = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              line_run,
  input  logic              tx_pop,
  output logic              tx_ready,
  output logic [DATA_W-1:0] tx_word,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_word,
  output logic              rx_room,
  output logic              irq
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  reg_addr_e         addr;
  logic              run_q, irq_q;
  logic [NFLAG-1:0]  flag_q, flag_d, en_q, en_d, set_vec;
  logic              wr_ctrl, wr_olen, wr_ilen, wr_flags, wr_en, wr_tx, rd_rx;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [LVL_W-1:0]  tx_level, rx_level, out_avail;
  logic [DATA_W-1:0] rx_head;
  logic              tx_take, rx_take, rx_pull;
  logic              o_svc, o_max, i_svc, i_max;

  assign addr     = reg_addr_e'(reg_addr);
  assign wr_ctrl  = reg_wr && addr == A_CTRL;
  assign wr_olen  = reg_wr && addr == A_OLEN && !run_q;
  assign wr_ilen  = reg_wr && addr == A_ILEN && !run_q;
  assign wr_flags = reg_wr && addr == A_FLAGS;
  assign wr_en    = reg_wr && addr == A_IRQEN;
  assign wr_tx    = reg_wr && addr == A_TXD;
  assign rd_rx    = reg_rd && addr == A_RXD;

  assign tx_ready = run_q & ~tx_empty;
  assign tx_take  = tx_pop & tx_ready;
  assign rx_room  = ~rx_full;
  assign rx_take  = rx_push & rx_room;
  assign rx_pull  = rd_rx & ~rx_empty;

  blksvc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) tx_fifo_i (
    .clk(clk), .rst(rst), .push(wr_tx), .wdata(reg_wdata), .pop(tx_take),
    .rdata(tx_word), .full(tx_full), .empty(tx_empty), .level(tx_level));

  blksvc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) rx_fifo_i (
    .clk(clk), .rst(rst), .push(rx_take), .wdata(rx_word), .pop(rx_pull),
    .rdata(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level));

  assign out_avail = LVL_W'(DEPTH) - tx_level;

  blksvc_dir #(.CNT_W(CNT_W), .LVL_W(LVL_W), .BLK(BLK)) out_dir_i (
    .clk(clk), .rst(rst), .restart(wr_olen), .len(reg_wdata[CNT_W-1:0]),
    .gate(run_q), .svc_flag(flag_q[F_OBLK]), .avail(out_avail),
    .sw_xfer(wr_tx & ~tx_full), .line_xfer(tx_take),
    .svc_set(o_svc), .max_set(o_max));

  blksvc_dir #(.CNT_W(CNT_W), .LVL_W(LVL_W), .BLK(BLK)) in_dir_i (
    .clk(clk), .rst(rst), .restart(wr_ilen), .len(reg_wdata[CNT_W-1:0]),
    .gate(1'b1), .svc_flag(flag_q[F_IBLK]), .avail(rx_level),
    .sw_xfer(rx_pull), .line_xfer(rx_take),
    .svc_set(i_svc), .max_set(i_max));

  always_comb begin
    set_vec         = '0;
    set_vec[F_OBLK] = o_svc;
    set_vec[F_IBLK] = i_svc;
    set_vec[F_OMAX] = o_max;
    set_vec[F_IMAX] = i_max;
    en_d   = wr_en ? reg_wdata[NFLAG-1:0] : en_q;
    flag_d = wr_flags ? (flag_q & ~reg_wdata[NFLAG-1:0]) : flag_q;
    flag_d = flag_d | set_vec;   // a new event wins over a same-cycle ack
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      flag_q    <= '0;
      en_q      <= '0;
      irq_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_ctrl) run_q <= reg_wdata[0];
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_q  <= |(flag_d & en_d);
      if (reg_rd) begin
        case (addr)
          A_CTRL:  reg_rdata <= DATA_W'(run_q);
          A_FLAGS: reg_rdata <= DATA_W'(flag_q);
          A_IRQEN: reg_rdata <= DATA_W'(en_q);
          A_RXD:   reg_rdata <= rx_head;
          A_LVL:   reg_rdata <= (DATA_W'(rx_level) << 8) | DATA_W'(tx_level);
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assign line_run = run_q;
  assign irq      = irq_q;
endmodule

// File: rtl/blksvc_chk.sv
`timescale 1ns/1ps
module blksvc_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [3:0]       ack_bits,
  input logic [3:0]       flags,
  input logic [3:0]       irq_en,
  input logic             irq,
  input logic             line_run,
  input logic [LVL_W-1:0] tx_level
);
  logic ack_wr;
  assign ack_wr = reg_wr && reg_addr == 3'd3;

  p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & irq_en));

  p_hold_oblk_r6: assert property (@(posedge clk) disable iff (rst)
    flags[0] && !(ack_wr && ack_bits[0]) |=> flags[0]);

  p_hold_imax_r6: assert property (@(posedge clk) disable iff (rst)
    flags[3] && !(ack_wr && ack_bits[3]) |=> flags[3]);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    flags[0] && ack_wr && ack_bits[0] |=> !flags[0]);

  p_paused_no_grant_r3: assert property (@(posedge clk) disable iff (rst)
    !line_run |=> !$rose(flags[0]));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LVL_W'(DEPTH));
endmodule

bind blksvc_top blksvc_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ack_bits(reg_wdata[3:0]), .flags(flag_q), .irq_en(en_q), .irq(irq),
  .line_run(line_run), .tx_level(tx_level));

// File: tb/blksvc_top_tb.sv
`timescale 1ns/1ps
module blksvc_top_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic          line_run, tx_pop = 1'b0, tx_ready, rx_push = 1'b0, rx_room, irq;
  logic [DW-1:0] tx_word, rx_word = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  blksvc_top #(.DATA_W(DW), .DEPTH(8), .BLK(4), .CNT_W(16)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_run(line_run),
    .tx_pop(tx_pop), .tx_ready(tx_ready), .tx_word(tx_word), .rx_push(rx_push),
    .rx_word(rx_word), .rx_room(rx_room), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic flag_chk(input string req, input logic [31:0] mask, input logic [31:0] exp);
    logic [31:0] d;
    idle(2);
    rd(3'd3, d);
    check(req, d & mask, exp);
  endtask

  task automatic lvl_chk(input string req, input logic [31:0] exp);
    logic [31:0] d;
    idle(1);
    rd(3'd7, d);
    check(req, d & 32'hFFFF, exp);
  endtask

  task automatic pop_tx(input string req, input logic [31:0] exp);
    @(negedge clk);
    check(req, {31'b0, tx_ready}, 32'd1);
    check(req, tx_word, exp);
    tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic pop_raw();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic push_rx(input logic [31:0] v);
    @(negedge clk); rx_push = 1'b1; rx_word = v;
    @(negedge clk); rx_push = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(4);
    rst = 1'b0;
    // R1 reset state
    idle(1);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 line_run", {31'b0, line_run}, 0);
    check("R1 tx_ready", {31'b0, tx_ready}, 0);
    flag_chk("R1 flags", 32'hF, 0);
    lvl_chk("R1 levels", 0);
    rd(3'd4, d); check("R1 irq enable", d, 0);

    // main transaction: 10 words each way, BLK=4, depth 8
    wr(3'd4, 32'hF);
    wr(3'd1, 10);
    wr(3'd2, 10);
    flag_chk("R3 paused no grant", 32'h1, 0);
    wr(3'd0, 1);
    check("R2 line_run", {31'b0, line_run}, 1);
    flag_chk("R3 run raises out block", 32'h1, 1);
    check("R8 irq on flag", {31'b0, irq}, 1);
    wr(3'd3, 1);
    flag_chk("R4 no regrant before data", 32'h1, 0);
    for (int i = 0; i < 4; i++) wr(3'd5, 100 + i);
    flag_chk("R4 regrant after block", 32'h1, 1);
    wr(3'd3, 1);
    for (int i = 4; i < 8; i++) wr(3'd5, 100 + i);
    flag_chk("R4 no grant without room", 32'h1, 0);
    lvl_chk("R10 tx level full", 8);
    pop_tx("R2 order", 100);
    pop_tx("R2 order", 101);
    flag_chk("R9 short final out block", 32'h1, 1);
    wr(3'd5, 108); wr(3'd5, 109);
    wr(3'd3, 1);
    flag_chk("R4 none past count", 32'h1, 0);
    for (int i = 2; i < 9; i++) pop_tx("R2 order", 100 + i);
    flag_chk("R7 out max not early", 32'h4, 0);
    pop_tx("R2 order", 109);
    flag_chk("R7 out max on last", 32'h4, 32'h4);

    for (int i = 0; i < 3; i++) push_rx(200 + i);
    flag_chk("R5 partial block no grant", 32'h2, 0);
    push_rx(203);
    flag_chk("R5 full block grant", 32'h2, 32'h2);
    for (int i = 0; i < 4; i++) begin rd(3'd6, d); check("R5 rx order", d, 200 + i); end
    wr(3'd3, 2);
    for (int i = 4; i < 8; i++) push_rx(200 + i);
    flag_chk("R5 second block", 32'h2, 32'h2);
    for (int i = 4; i < 8; i++) begin rd(3'd6, d); check("R5 rx order", d, 200 + i); end
    wr(3'd3, 2);
    push_rx(208);
    flag_chk("R9 short in block waits", 32'h2, 0);
    flag_chk("R7 in max not early", 32'h8, 0);
    push_rx(209);
    flag_chk("R9 R7 short in block and in max", 32'hA, 32'hA);
    for (int i = 8; i < 10; i++) begin rd(3'd6, d); check("R5 rx order", d, 200 + i); end
    wr(3'd3, 32'hE);
    flag_chk("R6 nothing pending", 32'hF, 0);
    check("R6 irq low", {31'b0, irq}, 0);

    // skipped acknowledge
    wr(3'd0, 0);
    check("R2 paused", {31'b0, line_run}, 0);
    wr(3'd1, 4);
    wr(3'd0, 1);
    flag_chk("R3 second run grant", 32'h1, 1);
    for (int i = 0; i < 4; i++) wr(3'd5, 300 + i);
    idle(5);
    check("R6 irq held unacked", {31'b0, irq}, 1);
    wr(3'd0, 0);
    wr(3'd1, 4);
    flag_chk("R6 survives new count", 32'h1, 1);
    wr(3'd4, 32'hE);
    check("R8 masked", {31'b0, irq}, 0);
    wr(3'd4, 32'hF);
    check("R8 unmasked", {31'b0, irq}, 1);
    wr(3'd3, 1);
    check("R6 ack drops irq", {31'b0, irq}, 0);

    // pause keeps counters
    check("R2 tx_ready paused", {31'b0, tx_ready}, 0);
    pop_raw();
    lvl_chk("R2 pop ignored paused", 4);
    wr(3'd0, 1);
    pop_tx("R11 order", 300);
    pop_tx("R11 order", 301);
    wr(3'd0, 0);
    pop_raw();
    lvl_chk("R11 level kept", 2);
    flag_chk("R11 no max yet", 32'h4, 0);
    wr(3'd0, 1);
    pop_tx("R11 order", 302);
    flag_chk("R11 no max at 3", 32'h4, 0);
    pop_tx("R11 order", 303);
    flag_chk("R11 max at total", 32'h4, 32'h4);
    pop_raw();
    lvl_chk("R10 empty pop ignored", 0);
    wr(3'd3, 32'hF);

    // overflow
    wr(3'd0, 0);
    wr(3'd1, 16);
    for (int i = 0; i < 9; i++) wr(3'd5, 400 + i);
    lvl_chk("R10 tx overflow dropped", 8);
    for (int i = 0; i < 9; i++) push_rx(500 + i);
    check("R10 rx_room full", {31'b0, rx_room}, 0);
    lvl_chk("R10 rx overflow dropped", 32'h0808);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule